// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home agent for a group of memory blocks in a small distributed shared-memory system with a fixed node count. For every block it keeps a coherence state (uncached, shared or exclusive), a one-bit-per-node sharer vector and an owner ID. The block data itself sits in a small internal memory array. Nodes send it read misses, write misses and dirty write-backs. For each request it sends invalidate or fetch commands to exactly the nodes that the directory names, not to every node. It waits for their answers and then returns the block data to the requester.

The controller works on one transaction at a time. A request is taken on a valid/ready handshake only while the controller is idle. The command and reply stream leaves on a valid/ready port: once `out_valid` is high, the message fields hold steady until `out_ready` takes the message, so a stalled network simply stretches the transaction. Answers from the nodes come back on a third valid/ready port. That port is ready only while a transaction is collecting answers. An answer from a node that is not being waited on is consumed and discarded. The directory entry is rewritten when the reply is taken, and a write-back takes effect in the cycle it is accepted.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with memory value zero, and `busy`, `out_valid` and `rsp_ready` are low while `req_ready` is high.
- R2: A read miss (`req_type` 0) to an uncached or shared block produces exactly one message: a data reply (`out_type` 0) to the requester carrying the memory value. Afterwards the requester is a sharer, and the block is shared.
- R3: A write miss (`req_type` 1) to an uncached block produces only a data reply with the memory value, and makes the requester the exclusive owner.
- R4: A write miss to a shared block first sends an invalidate (`out_type` 1) to every sharer other than the requester, in ascending node order. The data reply follows only once each of those nodes has answered. The requester then owns the block exclusively.
- R5: A read miss to an exclusive block sends a fetch (`out_type` 2) to the owner and waits for its data answer. It writes that data to memory and replies with it. The block becomes shared by the old owner and the requester.
- R6: A write miss to an exclusive block sends a fetch-and-invalidate (`out_type` 3) to the owner and replies with the owner's returned data. Memory also takes that data. The requester becomes the new exclusive owner.
- R7: A write-back (`req_type` 2) from the owner of an exclusive block stores `req_data` in memory and leaves the block uncached with an empty sharer set. A write-back from any other node, or to a block that is not exclusive, changes nothing. A write-back never produces a message or raises `busy`.
- R8: A read or write miss raises `busy` and drops `req_ready` in the cycle after it is accepted. Both return to idle in the cycle after the data reply is taken.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_type`, `out_node`, `out_blk` and `out_data` stay unchanged.
- R10: A node answer on the response port from a node that is not awaited is consumed without effect. It neither counts as an acknowledgement nor supplies reply data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on valid and ready |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no effect |
| req_node | input | NW | Requesting node ID |
| req_blk | input | BW | Block index |
| req_data | input | DW | Write-back data |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network accepts the message |
| out_type | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| out_node | output | NW | Destination node |
| out_blk | output | BW | Block the message concerns |
| out_data | output | DW | Block data for replies, zero otherwise |
| rsp_valid | input | 1 | Node answer present |
| rsp_ready | output | 1 | Controller collecting answers |
| rsp_node | input | NW | Answering node |
| rsp_data | input | DW | Returned block data for fetch answers |
| busy | output | 1 | Transaction in progress |

## Verification
The hardest case is a data reply that must be held back while answers arrive one at a time, late and with stalls on the message port. In the worst version, a stray answer from the wrong node shows up first and must not release the reply early. The bench gets there by building every sharer configuration of a block through ordinary read misses, and every owner through write misses. From each configuration it issues each kind of miss from each node. The bench answers each command only some cycles after it leaves the controller, and can first inject a stray answer from the requester. It then checks that the reply appears only after the last real answer has been delivered.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    BLK_U = 2'd0,
    BLK_S = 2'd1,
    BLK_E = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    REQ_RD = 2'd0,
    REQ_WR = 2'd1,
    REQ_WB = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_DATA      = 2'd0,
    MSG_INV       = 2'd1,
    MSG_FETCH     = 2'd2,
    MSG_FETCH_INV = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_XACT  = 2'd1,
    PH_REPLY = 2'd2
  } ctl_phase_e;

endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_blk,
  output blk_state_e        rd_state,
  output logic [NODES-1:0]  rd_sharers,
  output logic [NW-1:0]     rd_owner,
  output logic [DW-1:0]     rd_data,
  input  logic              dir_we,
  input  logic [BW-1:0]     wr_blk,
  input  blk_state_e        wr_state,
  input  logic [NODES-1:0]  wr_sharers,
  input  logic [NW-1:0]     wr_owner,
  input  logic              mem_we,
  input  logic [BW-1:0]     mem_blk,
  input  logic [DW-1:0]     mem_wdata
);

  blk_state_e       st_r  [BLOCKS];
  logic [NODES-1:0] shr_r [BLOCKS];
  logic [NW-1:0]    own_r [BLOCKS];
  logic [DW-1:0]    mem_r [BLOCKS];

  assign rd_state   = st_r[rd_blk];
  assign rd_sharers = shr_r[rd_blk];
  assign rd_owner   = own_r[rd_blk];
  assign rd_data    = mem_r[rd_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_r[b]  <= BLK_U;
        shr_r[b] <= '0;
        own_r[b] <= '0;
        mem_r[b] <= '0;
      end
    end else begin
      if (dir_we) begin
        st_r[wr_blk]  <= wr_state;
        shr_r[wr_blk] <= wr_sharers;
        own_r[wr_blk] <= wr_owner;
      end
      if (mem_we) begin
        mem_r[mem_blk] <= mem_wdata;
      end
    end
  end

endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [1:0]        kind,
  input  logic [NW-1:0]     node,
  input  blk_state_e        cur_state,
  input  logic [NODES-1:0]  cur_sharers,
  input  logic [NW-1:0]     cur_owner,
  output logic              is_miss,
  output logic              wb_hit,
  output logic [NODES-1:0]  target_mask,
  output logic [1:0]        target_kind,
  output logic              want_data,
  output blk_state_e        nx_state,
  output logic [NODES-1:0]  nx_sharers,
  output logic [NW-1:0]     nx_owner
);

  logic [NODES-1:0] req_bit;
  logic [NODES-1:0] own_bit;
  logic [NODES-1:0] owner_other;

  assign req_bit     = NODES'(1) << node;
  assign own_bit     = NODES'(1) << cur_owner;
  assign owner_other = own_bit & ~req_bit;

  always_comb begin
    is_miss     = (kind == REQ_RD) || (kind == REQ_WR);
    wb_hit      = (kind == REQ_WB) && (cur_state == BLK_E) && (cur_owner == node);
    target_mask = '0;
    target_kind = MSG_INV;
    want_data   = 1'b0;
    nx_state    = cur_state;
    nx_sharers  = cur_sharers;
    nx_owner    = cur_owner;
    if (kind == REQ_RD) begin
      case (cur_state)
        BLK_S: nx_sharers = cur_sharers | req_bit;
        BLK_E: begin
          target_mask = owner_other;
          target_kind = MSG_FETCH;
          want_data   = |owner_other;
          nx_state    = BLK_S;
          nx_sharers  = own_bit | req_bit;
        end
        default: begin
          nx_state   = BLK_S;
          nx_sharers = req_bit;
        end
      endcase
    end else if (kind == REQ_WR) begin
      nx_state   = BLK_E;
      nx_sharers = req_bit;
      nx_owner   = node;
      case (cur_state)
        BLK_S: begin
          target_mask = cur_sharers & ~req_bit;
          target_kind = MSG_INV;
        end
        BLK_E: begin
          target_mask = owner_other;
          target_kind = MSG_FETCH_INV;
          want_data   = |owner_other;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign onehot[i]  = mask[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | mask[i];
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (onehot[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  input  logic [DW-1:0] req_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_type,
  output logic [NW-1:0] out_node,
  output logic [BW-1:0] out_blk,
  output logic [DW-1:0] out_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [NW-1:0] rsp_node,
  input  logic [DW-1:0] rsp_data,
  output logic          busy
);

  ctl_phase_e       ph_q;
  logic [NW-1:0]    node_q;
  logic [BW-1:0]    blk_q;
  logic [NODES-1:0] send_q;
  logic [NODES-1:0] wait_q;
  logic [1:0]       skind_q;
  logic             need_q;
  logic [DW-1:0]    data_q;
  blk_state_e       nst_q;
  logic [NODES-1:0] nshr_q;
  logic [NW-1:0]    nown_q;

  logic             idle;
  logic             accept;
  logic [BW-1:0]    look_blk;
  blk_state_e       cur_state;
  logic [NODES-1:0] cur_sharers;
  logic [NW-1:0]    cur_owner;
  logic [DW-1:0]    cur_data;

  logic             pol_miss;
  logic             pol_wb_hit;
  logic [NODES-1:0] pol_mask;
  logic [1:0]       pol_kind;
  logic             pol_want;
  blk_state_e       pol_state;
  logic [NODES-1:0] pol_sharers;
  logic [NW-1:0]    pol_owner;

  logic [NODES-1:0] pick_onehot;
  logic [NW-1:0]    pick_idx;
  logic             out_fire;
  logic             rsp_hit;
  logic             wb_apply;
  logic             commit;

  logic             dir_we;
  logic [BW-1:0]    wr_blk;
  blk_state_e       wr_state;
  logic [NODES-1:0] wr_sharers;
  logic [NW-1:0]    wr_owner;
  logic             mem_we;
  logic [DW-1:0]    mem_wdata;

  assign idle     = (ph_q == PH_IDLE);
  assign accept   = idle && req_valid;
  assign look_blk = idle ? req_blk : blk_q;

  dir_store #(
    .NODES (NODES),
    .BLOCKS(BLOCKS),
    .DW    (DW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_blk    (look_blk),
    .rd_state  (cur_state),
    .rd_sharers(cur_sharers),
    .rd_owner  (cur_owner),
    .rd_data   (cur_data),
    .dir_we    (dir_we),
    .wr_blk    (wr_blk),
    .wr_state  (wr_state),
    .wr_sharers(wr_sharers),
    .wr_owner  (wr_owner),
    .mem_we    (mem_we),
    .mem_blk   (wr_blk),
    .mem_wdata (mem_wdata)
  );

  dir_policy #(
    .NODES(NODES)
  ) u_policy (
    .kind       (req_type),
    .node       (req_node),
    .cur_state  (cur_state),
    .cur_sharers(cur_sharers),
    .cur_owner  (cur_owner),
    .is_miss    (pol_miss),
    .wb_hit     (pol_wb_hit),
    .target_mask(pol_mask),
    .target_kind(pol_kind),
    .want_data  (pol_want),
    .nx_state   (pol_state),
    .nx_sharers (pol_sharers),
    .nx_owner   (pol_owner)
  );

  dir_lowest_pick #(
    .N(NODES)
  ) u_pick (
    .mask  (send_q),
    .onehot(pick_onehot),
    .idx   (pick_idx)
  );

  // Outgoing message mux: commands during collection, data reply at the end.
  always_comb begin
    out_valid = 1'b0;
    out_type  = MSG_DATA;
    out_node  = node_q;
    out_blk   = blk_q;
    out_data  = '0;
    case (ph_q)
      PH_XACT: begin
        out_valid = |send_q;
        out_type  = skind_q;
        out_node  = pick_idx;
      end
      PH_REPLY: begin
        out_valid = 1'b1;
        out_data  = data_q;
      end
      default: ;
    endcase
  end

  assign out_fire  = out_valid && out_ready;
  assign rsp_ready = (ph_q == PH_XACT);
  assign rsp_hit   = rsp_ready && rsp_valid && wait_q[rsp_node];
  assign req_ready = idle;
  assign busy      = !idle;

  assign wb_apply = accept && pol_wb_hit;
  assign commit   = (ph_q == PH_REPLY) && out_ready;

  // Single directory/memory write port shared by write-back and commit paths.
  assign dir_we     = wb_apply || commit;
  assign wr_blk     = idle ? req_blk : blk_q;
  assign wr_state   = idle ? BLK_U : nst_q;
  assign wr_sharers = idle ? '0 : nshr_q;
  assign wr_owner   = idle ? '0 : nown_q;
  assign mem_we     = wb_apply || (rsp_hit && need_q);
  assign mem_wdata  = idle ? req_data : rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      node_q  <= '0;
      blk_q   <= '0;
      send_q  <= '0;
      wait_q  <= '0;
      skind_q <= MSG_INV;
      need_q  <= 1'b0;
      data_q  <= '0;
      nst_q   <= BLK_U;
      nshr_q  <= '0;
      nown_q  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (accept && pol_miss) begin
            node_q  <= req_node;
            blk_q   <= req_blk;
            send_q  <= pol_mask;
            wait_q  <= pol_mask;
            skind_q <= pol_kind;
            need_q  <= pol_want;
            data_q  <= cur_data;
            nst_q   <= pol_state;
            nshr_q  <= pol_sharers;
            nown_q  <= pol_owner;
            ph_q    <= PH_XACT;
          end
        end
        PH_XACT: begin
          if (out_fire) begin
            send_q <= send_q & ~pick_onehot;
          end
          if (rsp_hit) begin
            wait_q <= wait_q & ~(NODES'(1) << rsp_node);
            if (need_q) data_q <= rsp_data;
          end
          if ((send_q == '0) && (wait_q == '0)) begin
            ph_q <= PH_REPLY;
          end
        end
        PH_REPLY: begin
          if (out_ready) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_type,
  input logic [NW-1:0]    out_node,
  input logic [BW-1:0]    out_blk,
  input logic [DW-1:0]    out_data,
  input logic             rsp_ready,
  input logic             busy,
  input logic [NODES-1:0] wait_mask,
  input logic [NW-1:0]    req_node_q
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !out_valid));

  assert_reply_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == 2'd0) |-> (out_node == req_node_q));

  assert_reply_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_type == 2'd0) |=> !busy);

  assert_reply_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == 2'd0) |-> (wait_mask == '0));

  assert_inv_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == 2'd1) |-> (out_node != req_node_q));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_node)
                                   && $stable(out_blk) && $stable(out_data)));

  assert_rsp_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy);

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
  .NODES (NODES),
  .BLOCKS(BLOCKS),
  .DW    (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_type  (out_type),
  .out_node  (out_node),
  .out_blk   (out_blk),
  .out_data  (out_data),
  .rsp_ready (rsp_ready),
  .busy      (busy),
  .wait_mask (wait_q),
  .req_node_q(node_q)
);

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;

  localparam int NODES  = 4;
  localparam int BLOCKS = 8;
  localparam int DW     = 16;
  localparam int NW     = 2;
  localparam int BW     = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_type = '0;
  logic [NW-1:0] req_node = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [1:0]    out_type;
  logic [NW-1:0] out_node;
  logic [BW-1:0] out_blk;
  logic [DW-1:0] out_data;
  logic          rsp_valid = 1'b0;
  logic          rsp_ready;
  logic [NW-1:0] rsp_node = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          busy;

  always #4 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_node(out_node), .out_blk(out_blk), .out_data(out_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
    .rsp_data(rsp_data), .busy(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int txn     = 0;
  logic [15:0] lf = 16'hACE1;

  // Reference directory: 0 uncached, 1 shared, 2 exclusive
  int               m_st  [BLOCKS];
  logic [NODES-1:0] m_shr [BLOCKS];
  int               m_own [BLOCKS];
  logic [DW-1:0]    m_mem [BLOCKS];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= 190000);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=%0d expected<190000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input int kind, input int node, input int blk,
                         input logic [DW-1:0] wd, input bit inject);
    int en;
    int et [8];
    int enode [8];
    logic [DW-1:0] edat [8];
    string tag;
    logic [31:0] tmix;
    logic [DW-1:0] fval;
    int o, nst, nown, got, qh, qt, rsp_sent, gap, guard;
    logic [NODES-1:0] nshr;
    logic [DW-1:0] nmem;
    int qn [8];
    int qk [8];
    bit inj_left, done, hold_v, push_v, rdy;
    int hold_t, hold_n, hold_b, push_n, push_k;
    logic [DW-1:0] hold_d;

    txn++;
    tmix = txn * 40503 + node * 17 + blk * 3;
    fval = tmix[15:0] ^ 16'h5A5A;
    o = m_own[blk];
    en = 0; nst = m_st[blk]; nshr = m_shr[blk]; nown = m_own[blk]; nmem = m_mem[blk];
    tag = "R2";
    if (kind == 0) begin
      if (m_st[blk] == 2) begin
        tag = "R5";
        et[en] = 2; enode[en] = o; edat[en] = '0; en++;
        et[en] = 0; enode[en] = node; edat[en] = fval; en++;
        nst = 1; nshr = (NODES'(1) << o) | (NODES'(1) << node); nmem = fval;
      end else begin
        et[en] = 0; enode[en] = node; edat[en] = m_mem[blk]; en++;
        nshr = (m_st[blk] == 1) ? (m_shr[blk] | (NODES'(1) << node)) : (NODES'(1) << node);
        nst = 1;
      end
    end else if (kind == 1) begin
      if (m_st[blk] == 0) begin
        tag = "R3";
        et[en] = 0; enode[en] = node; edat[en] = m_mem[blk]; en++;
      end else if (m_st[blk] == 1) begin
        tag = "R4";
        for (int i = 0; i < NODES; i++) begin
          if (m_shr[blk][i] && i != node) begin
            et[en] = 1; enode[en] = i; edat[en] = '0; en++;
          end
        end
        et[en] = 0; enode[en] = node; edat[en] = m_mem[blk]; en++;
      end else begin
        tag = "R6";
        et[en] = 3; enode[en] = o; edat[en] = '0; en++;
        et[en] = 0; enode[en] = node; edat[en] = fval; en++;
        nmem = fval;
      end
      nst = 2; nshr = NODES'(1) << node; nown = node;
    end else begin
      tag = "R7";
      if (m_st[blk] == 2 && o == node) begin
        nmem = wd; nst = 0; nshr = '0; nown = 0;
      end
    end
    if (inject && kind != 2) tag = {tag, "/R10"};

    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "req_ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_type  = 2'(kind);
    req_node  = NW'(node);
    req_blk   = BW'(blk);
    req_data  = wd;
    @(negedge clk);
    req_valid = 1'b0;

    if (kind == 2) begin
      chk(busy == 1'b0, "R7", "busy after write-back", busy, 0);
      chk(out_valid == 1'b0, "R7", "message after write-back", out_valid, 0);
    end else begin
      chk(busy == 1'b1, "R8", "busy after miss accepted", busy, 1);
      chk(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
      inj_left = inject; qh = 0; qt = 0; rsp_sent = 0; gap = 1; got = 0;
      done = 0; hold_v = 0; guard = 0;
      while (!done && guard < 300) begin
        push_v = 0;
        if (hold_v) begin
          chk(out_valid && out_type == 2'(hold_t) && out_node == NW'(hold_n) &&
              out_blk == BW'(hold_b) && out_data == hold_d,
              "R9", "message held under stall", {out_valid, out_type, out_node, out_data},
              {1'b1, 2'(hold_t), NW'(hold_n), hold_d});
        end
        step_lf();
        rdy = (lf[3:0] > 4'd4);
        out_ready = rdy;
        hold_v = 0;
        if (out_valid && rdy) begin
          if (got < en) begin
            chk(out_type == 2'(et[got]), tag, "message type", out_type, et[got]);
            chk(out_node == NW'(enode[got]), tag, "message node", out_node, enode[got]);
            chk(out_blk == BW'(blk), tag, "message block", out_blk, blk);
            chk(out_data == edat[got], tag, "message data", out_data, edat[got]);
          end else begin
            chk(1'b0, tag, "unexpected extra message", got + 1, en);
          end
          got++;
          if (out_type == 2'd0) begin
            done = 1;
            chk(rsp_sent == en - 1, tag, "reply only after all answers", rsp_sent, en - 1);
          end else begin
            push_v = 1; push_n = int'(out_node); push_k = int'(out_type);
          end
        end else if (out_valid) begin
          hold_v = 1; hold_t = int'(out_type); hold_n = int'(out_node);
          hold_b = int'(out_blk); hold_d = out_data;
        end
        rsp_valid = 1'b0;
        if (inj_left && rsp_ready) begin
          rsp_valid = 1'b1; rsp_node = NW'(node); rsp_data = 16'hBEEF; inj_left = 0;
        end else if (qh < qt && gap == 0 && rsp_ready) begin
          rsp_valid = 1'b1; rsp_node = NW'(qn[qh]);
          rsp_data = (qk[qh] == 1) ? 16'hDEAD : fval;
          qh++; rsp_sent++;
          step_lf();
          gap = int'(lf[1:0]);
        end else if (gap > 0) begin
          gap--;
        end
        if (push_v) begin
          qn[qt] = push_n; qk[qt] = push_k; qt++;
        end
        @(negedge clk);
        guard++;
      end
      rsp_valid = 1'b0;
      out_ready = 1'b0;
      chk(done, tag, "data reply seen", done, 1);
      chk(got == en, tag, "message count", got, en);
      chk(busy == 1'b0, "R8", "busy after reply", busy, 0);
    end
    m_st[blk] = nst; m_shr[blk] = nshr; m_own[blk] = nown; m_mem[blk] = nmem;
  endtask

  task automatic to_uncached(input int blk);
    if (m_st[blk] == 1) run_req(1, 0, blk, '0, 1'b0);
    if (m_st[blk] == 2) begin
      step_lf();
      run_req(2, m_own[blk], blk, lf, 1'b0);
    end
  endtask

  task automatic set_cfg(input int blk, input int cfg);
    to_uncached(blk);
    if (cfg >= 1 && cfg <= 15) begin
      for (int i = 0; i < NODES; i++) if (cfg[i]) run_req(0, i, blk, '0, 1'b0);
    end else if (cfg >= 16) begin
      run_req(1, cfg - 16, blk, '0, 1'b0);
    end
  endtask

  initial begin
    for (int b = 0; b < BLOCKS; b++) begin
      m_st[b] = 0; m_shr[b] = '0; m_own[b] = 0; m_mem[b] = '0;
    end
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(rsp_ready == 1'b0, "R1", "rsp_ready in reset", rsp_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // R1: every block starts uncached with zero data (reply value 0, single message)
    for (int b = 0; b < BLOCKS; b++) run_req(0, b % NODES, b, '0, 1'b0);

    // Near-exhaustive: every sharer mask and owner, each miss kind from each node
    for (int blk = 0; blk < BLOCKS; blk += 3) begin
      for (int cfg = 0; cfg < 20; cfg++) begin
        for (int op = 0; op < 2; op++) begin
          for (int n = 0; n < NODES; n++) begin
            set_cfg(blk, cfg);
            if (m_st[blk] == 2 && m_own[blk] == n) begin
              step_lf();
              run_req(2, (n + 1) % NODES, blk, lf, 1'b0);   // R7 ignored write-back
              step_lf();
              run_req(2, n, blk, lf, 1'b0);                 // R7 owner write-back
              run_req(op, n, blk, '0, 1'b0);
            end else begin
              run_req(op, n, blk, '0, (n + cfg) % 3 == 0);
            end
          end
        end
      end
    end

    // Mixed traffic over all blocks, with stray answers (R10) and stray write-backs (R7)
    for (int k = 0; k < 500; k++) begin
      int kind, node, blk;
      bit inj;
      step_lf(); kind = int'(lf[1:0]) % 3;
      step_lf(); node = int'(lf[1:0]);
      step_lf(); blk  = int'(lf[2:0]);
      step_lf(); inj  = lf[0];
      if (kind < 2 && m_st[blk] == 2 && m_own[blk] == node) kind = 2;
      step_lf();
      run_req(kind, node, blk, lf, inj);
    end

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule